// File: doc/BRIEF.md
# User-Mode Kernel-Address Access Checker

This block sits in front of the first stage of virtual address translation. It decides whether an access must fault because code running at user level is reaching into the upper, kernel half of the virtual address space. The decision uses several inputs: the current privilege and virtualization state, the memory-privilege-modify controls, and whether the access comes from a hypervisor load/store instruction. From these it works out the effective privilege of the access. It then picks one of two enable bits, the supervisor-level one or the hypervisor-level one, according to how that user-level privilege came about. Finally it tests a single address bit, whose position comes from the supervisor XLEN setting.

The check runs only when all of the following hold: the extension is enabled, the access belongs to the first translation stage, and the address-translation register selects the 39-bit paged mode. When an access violates the rule, the block reports a page fault of the same kind as the access. The decision logic is combinational. Its result is captured on a valid-qualified request and presented one cycle later with a matching valid.

A two-state controller tracks the response slot. IDLE means no result is presented. HOLD means a registered result is on the outputs. There are three transitions. ACCEPT goes from IDLE to HOLD when req_valid is high. CHAIN keeps HOLD while back-to-back requests arrive. DRAIN returns from HOLD to IDLE when req_valid is low. Reset forces IDLE.

Top module: `ukaddr_guard`

## Requirements
- R1: While rst is high the block is in IDLE and rsp_valid is low. After reset, rsp_valid is high in a cycle exactly when req_valid was high at the previous rising edge.
- R2: Only fetches (acc_kind 0), loads (acc_kind 1) and stores/AMOs (acc_kind 2) are checked. An access with acc_kind 3 never faults.
- R3: The check is skipped, and the access passes, in three cases: ext_en is 0, stage_one is 0, or atp_mode differs from 8.
- R4: Privilege is encoded as 0 = U, 1 = S, 2 = reserved, 3 = M. The access is at user level, and therefore checked, in four cases. First, cur_priv is U with any cur_virt. Second, cur_priv is M with mprv=1 and mpp=0. Third, hyp_access=1 with cur_virt=0 from S or M, with spvp=0. Fourth, hyp_access=1 with cur_virt=0 from U, with hu=1. Every other combination passes, including any hyp_access with cur_virt=1 and plain S or M accesses.
- R5: The enable is taken from hyp_guard_en when cur_priv is U, cur_virt is 0 and hyp_access is 1. In every other case it is taken from usr_guard_en.
- R6: A user-level access whose selected enable bit is 0 passes.
- R7: The tested address bit is bit 31 when sxl is 0 or 1, and bit 63 (the top address bit) when sxl is 2 or 3. A checked, enabled access faults when that bit is 1 and passes when it is 0.
- R8: rsp_cause carries the fault code: 12 for a fetch, 13 for a load, 15 for a store/AMO. It is 0 whenever rsp_fault is 0.
- R9: In a cycle without a response (rsp_valid low), rsp_fault and rsp_cause are both 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request qualifier for the current access |
| cur_priv | input | 2 | Current privilege (0 U, 1 S, 3 M) |
| cur_virt | input | 1 | Virtualization currently on |
| mprv | input | 1 | Memory-privilege-modify enable |
| mpp | input | 2 | Previous privilege used when mprv is set |
| hyp_access | input | 1 | Access comes from a hypervisor load/store instruction |
| spvp | input | 1 | Guest privilege for hypervisor accesses from S/M (0 = user) |
| hu | input | 1 | Hypervisor load/store permitted from U-mode |
| atp_mode | input | 4 | Translation-mode field (8 = 39-bit paged) |
| usr_guard_en | input | 1 | Supervisor-level enable bit |
| hyp_guard_en | input | 1 | Hypervisor-level enable bit |
| sxl | input | 2 | Supervisor XLEN encoding |
| ext_en | input | 1 | Extension enabled in configuration |
| stage_one | input | 1 | Access belongs to the first translation stage |
| acc_kind | input | 2 | 0 fetch, 1 load, 2 store/AMO, 3 other |
| vaddr | input | VA_W | Virtual address of the access |
| rsp_valid | output | 1 | Registered result is present |
| rsp_fault | output | 1 | Access must raise a page fault |
| rsp_cause | output | 5 | Page-fault cause code, 0 when passing |

## Verification
Every result appears one rising edge after the edge that captured its request. So rsp_valid, rsp_fault and rsp_cause for a request driven before edge N are read between edges N and N+1. The bench therefore changes inputs on the falling edge and reads the outputs on the next falling edge, one whole clock after the change. Back-to-back requests test the CHAIN path. A dropped request is read one falling edge later to observe DRAIN and the cleared fault and cause. Reset applied during a request is read at the first falling edge after the edge at which it is sampled.

// File: rtl/ukg_pkg.sv
package ukg_pkg;

    typedef enum logic [1:0] {
        PRIV_U   = 2'd0,
        PRIV_S   = 2'd1,
        PRIV_RSV = 2'd2,
        PRIV_M   = 2'd3
    } priv_e;

    typedef enum logic [1:0] {
        ACC_FETCH = 2'd0,
        ACC_LOAD  = 2'd1,
        ACC_STORE = 2'd2,
        ACC_OTHER = 2'd3
    } acc_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_HOLD = 1'b1
    } rsp_state_e;

    localparam int          CAUSE_W     = 5;
    localparam int          MODE_W      = 4;
    localparam logic [MODE_W-1:0] MODE_PAGED39 = 4'd8;

    localparam logic [CAUSE_W-1:0] CAUSE_NONE   = 5'd0;
    localparam logic [CAUSE_W-1:0] CAUSE_IFETCH = 5'd12;
    localparam logic [CAUSE_W-1:0] CAUSE_LOAD   = 5'd13;
    localparam logic [CAUSE_W-1:0] CAUSE_STORE  = 5'd15;

endpackage

// File: rtl/ukg_priv_resolve.sv
module ukg_priv_resolve
    import ukg_pkg::*;
(
    input  logic [1:0] cur_priv,
    input  logic       cur_virt,
    input  logic       mprv,
    input  logic [1:0] mpp,
    input  logic       hyp_access,
    input  logic       spvp,
    input  logic       hu,
    input  logic       usr_guard_en,
    input  logic       hyp_guard_en,
    output logic       eff_user,
    output logic       guard_en
);

    logic from_user_host;

    // A hypervisor access issued from host user level steers the enable choice.
    assign from_user_host = (cur_priv == PRIV_U) && !cur_virt && hyp_access;

    always_comb begin
        eff_user = 1'b0;
        if (hyp_access) begin
            if (!cur_virt) begin
                if (cur_priv == PRIV_U) begin
                    eff_user = hu;
                end else if (cur_priv != PRIV_RSV) begin
                    eff_user = !spvp;
                end
            end
        end else if ((cur_priv == PRIV_M) && mprv) begin
            eff_user = (mpp == PRIV_U);
        end else begin
            eff_user = (cur_priv == PRIV_U);
        end
    end

    always_comb begin
        if (from_user_host) begin
            guard_en = hyp_guard_en;
        end else begin
            guard_en = usr_guard_en;
        end
    end

endmodule

// File: rtl/ukg_addr_probe.sv
module ukg_addr_probe #(
    parameter int VA_W     = 64,
    parameter int NARROW_W = 32
) (
    input  logic [1:0]      sxl,
    input  logic [VA_W-1:0] vaddr,
    output logic            top_set
);

    localparam int WIDE_BIT   = VA_W - 1;
    localparam int NARROW_BIT = NARROW_W - 1;

    generate
        if (VA_W > NARROW_W) begin : g_two_widths
            // Encodings 0 and 1 select the narrow width, 2 and 3 the full bus.
            assign top_set = sxl[1] ? vaddr[WIDE_BIT] : vaddr[NARROW_BIT];
        end else begin : g_one_width
            logic unused_sxl;
            assign unused_sxl = ^sxl;
            assign top_set    = vaddr[WIDE_BIT];
        end
    endgenerate

endmodule

// File: rtl/ukg_verdict.sv
module ukg_verdict
    import ukg_pkg::*;
(
    input  logic                ext_en,
    input  logic                stage_one,
    input  logic [MODE_W-1:0]   atp_mode,
    input  logic [1:0]          acc_kind,
    input  logic                eff_user,
    input  logic                guard_en,
    input  logic                top_set,
    output logic                fault,
    output logic [CAUSE_W-1:0]  cause
);

    logic armed;
    logic kind_checked;
    logic [CAUSE_W-1:0] kind_cause;

    assign armed = ext_en && stage_one && (atp_mode == MODE_PAGED39);

    always_comb begin
        kind_checked = 1'b1;
        kind_cause   = CAUSE_NONE;
        unique case (acc_kind)
            ACC_FETCH: kind_cause = CAUSE_IFETCH;
            ACC_LOAD:  kind_cause = CAUSE_LOAD;
            ACC_STORE: kind_cause = CAUSE_STORE;
            default:   kind_checked = 1'b0;
        endcase
    end

    assign fault = armed && kind_checked && eff_user && guard_en && top_set;
    assign cause = fault ? kind_cause : CAUSE_NONE;

endmodule

// File: rtl/ukaddr_guard.sv
module ukaddr_guard
    import ukg_pkg::*;
#(
    parameter int VA_W = 64
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 req_valid,
    input  logic [1:0]           cur_priv,
    input  logic                 cur_virt,
    input  logic                 mprv,
    input  logic [1:0]           mpp,
    input  logic                 hyp_access,
    input  logic                 spvp,
    input  logic                 hu,
    input  logic [3:0]           atp_mode,
    input  logic                 usr_guard_en,
    input  logic                 hyp_guard_en,
    input  logic [1:0]           sxl,
    input  logic                 ext_en,
    input  logic                 stage_one,
    input  logic [1:0]           acc_kind,
    input  logic [VA_W-1:0]      vaddr,
    output logic                 rsp_valid,
    output logic                 rsp_fault,
    output logic [CAUSE_W-1:0]   rsp_cause
);

    localparam int NARROW_W = 32;

    rsp_state_e         state_q;
    rsp_state_e         state_d;
    logic               eff_user;
    logic               guard_en;
    logic               top_set;
    logic               v_fault;
    logic [CAUSE_W-1:0] v_cause;
    logic               fault_q;
    logic [CAUSE_W-1:0] cause_q;

    ukg_priv_resolve u_priv (
        .cur_priv     (cur_priv),
        .cur_virt     (cur_virt),
        .mprv         (mprv),
        .mpp          (mpp),
        .hyp_access   (hyp_access),
        .spvp         (spvp),
        .hu           (hu),
        .usr_guard_en (usr_guard_en),
        .hyp_guard_en (hyp_guard_en),
        .eff_user     (eff_user),
        .guard_en     (guard_en)
    );

    ukg_addr_probe #(
        .VA_W     (VA_W),
        .NARROW_W (NARROW_W)
    ) u_probe (
        .sxl     (sxl),
        .vaddr   (vaddr),
        .top_set (top_set)
    );

    ukg_verdict u_verdict (
        .ext_en    (ext_en),
        .stage_one (stage_one),
        .atp_mode  (atp_mode),
        .acc_kind  (acc_kind),
        .eff_user  (eff_user),
        .guard_en  (guard_en),
        .top_set   (top_set),
        .fault     (v_fault),
        .cause     (v_cause)
    );

    // Next-state: ACCEPT, CHAIN and DRAIN all follow req_valid.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: state_d = req_valid ? ST_HOLD : ST_IDLE;
            ST_HOLD: state_d = req_valid ? ST_HOLD : ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Output register: a result is captured only with a request.
    always_ff @(posedge clk) begin
        if (rst) begin
            fault_q <= 1'b0;
            cause_q <= CAUSE_NONE;
        end else if (req_valid) begin
            fault_q <= v_fault;
            cause_q <= v_cause;
        end else begin
            fault_q <= 1'b0;
            cause_q <= CAUSE_NONE;
        end
    end

    assign rsp_valid = (state_q == ST_HOLD);
    assign rsp_fault = fault_q;
    assign rsp_cause = cause_q;

endmodule

// File: rtl/ukg_checker.sv
module ukg_checker #(
    parameter int VA_W = 64
) (
    input logic            clk,
    input logic            rst,
    input logic            req_valid,
    input logic [1:0]      cur_priv,
    input logic            mprv,
    input logic            hyp_access,
    input logic [3:0]      atp_mode,
    input logic [1:0]      sxl,
    input logic            ext_en,
    input logic            stage_one,
    input logic [1:0]      acc_kind,
    input logic [VA_W-1:0] vaddr,
    input logic            rsp_valid,
    input logic            rsp_fault,
    input logic [4:0]      rsp_cause
);

    p_reset_idle_r1: assert property (@(posedge clk)
        rst |=> !rsp_valid);

    p_valid_track_r1: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> rsp_valid);

    p_quiet_when_idle_r9: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> (!rsp_valid && !rsp_fault && rsp_cause == 5'd0));

    p_other_kind_pass_r2: assert property (@(posedge clk) disable iff (rst)
        (req_valid && acc_kind == 2'd3) |=> !rsp_fault);

    p_gated_pass_r3: assert property (@(posedge clk) disable iff (rst)
        (req_valid && (atp_mode != 4'd8 || !ext_en || !stage_one)) |=> !rsp_fault);

    p_machine_pass_r4: assert property (@(posedge clk) disable iff (rst)
        (req_valid && cur_priv == 2'd3 && !mprv && !hyp_access) |=> !rsp_fault);

    p_low_wide_pass_r7: assert property (@(posedge clk) disable iff (rst)
        (req_valid && sxl == 2'd2 && !vaddr[VA_W-1]) |=> !rsp_fault);

    p_cause_legal_r8: assert property (@(posedge clk) disable iff (rst)
        rsp_fault |-> (rsp_cause == 5'd12 || rsp_cause == 5'd13 || rsp_cause == 5'd15));

    p_fetch_cause_r8: assert property (@(posedge clk) disable iff (rst)
        (req_valid && acc_kind == 2'd0) |=> (!rsp_fault || rsp_cause == 5'd12));

    p_pass_zero_cause_r8: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && !rsp_fault) |-> rsp_cause == 5'd0);

endmodule

bind ukaddr_guard ukg_checker #(.VA_W(VA_W)) u_ukg_checker (
    .clk        (clk),
    .rst        (rst),
    .req_valid  (req_valid),
    .cur_priv   (cur_priv),
    .mprv       (mprv),
    .hyp_access (hyp_access),
    .atp_mode   (atp_mode),
    .sxl        (sxl),
    .ext_en     (ext_en),
    .stage_one  (stage_one),
    .acc_kind   (acc_kind),
    .vaddr      (vaddr),
    .rsp_valid  (rsp_valid),
    .rsp_fault  (rsp_fault),
    .rsp_cause  (rsp_cause)
);

// File: tb/tb_ukaddr_guard.sv
module tb_ukaddr_guard;

    localparam int CLK_PERIOD = 10;
    localparam int VA_W       = 64;
    localparam int N_VEC      = 23;
    localparam int N_RAND     = 400;

    typedef struct packed {
        logic [1:0]  priv;
        logic        virt;
        logic        mprv;
        logic [1:0]  mpp;
        logic        hyp;
        logic        spvp;
        logic        hu;
        logic [3:0]  mode;
        logic        sen;
        logic        hen;
        logic [1:0]  sxl;
        logic        ext;
        logic        stg;
        logic [1:0]  kind;
        logic [63:0] addr;
        logic        flt;
        logic [4:0]  cause;
    } vec_t;

    localparam logic [63:0] KA   = 64'h8000_0000_0000_0000;
    localparam logic [63:0] LA32 = 64'h0000_0000_8000_0000;

    // priv virt mprv mpp hyp spvp hu mode sen hen sxl ext stg kind addr flt cause
    localparam vec_t VT [0:N_VEC-1] = '{
        '{2'd0,1'b0,1'b0,2'd0,1'b0,1'b0,1'b0,4'd8,1'b1,1'b0,2'd2,1'b1,1'b1,2'd1,KA,  1'b1,5'd13}, // R4 R8 load
        '{2'd0,1'b0,1'b0,2'd0,1'b0,1'b0,1'b0,4'd8,1'b1,1'b0,2'd2,1'b1,1'b1,2'd2,KA,  1'b1,5'd15}, // R8 store
        '{2'd0,1'b0,1'b0,2'd0,1'b0,1'b0,1'b0,4'd8,1'b1,1'b0,2'd2,1'b1,1'b1,2'd0,KA,  1'b1,5'd12}, // R8 fetch
        '{2'd0,1'b0,1'b0,2'd0,1'b0,1'b0,1'b0,4'd8,1'b1,1'b0,2'd2,1'b1,1'b1,2'd3,KA,  1'b0,5'd0},  // R2 other
        '{2'd0,1'b0,1'b0,2'd0,1'b0,1'b0,1'b0,4'd0,1'b1,1'b0,2'd2,1'b1,1'b1,2'd1,KA,  1'b0,5'd0},  // R3 mode
        '{2'd0,1'b0,1'b0,2'd0,1'b0,1'b0,1'b0,4'd8,1'b1,1'b0,2'd2,1'b0,1'b1,2'd1,KA,  1'b0,5'd0},  // R3 ext off
        '{2'd0,1'b0,1'b0,2'd0,1'b0,1'b0,1'b0,4'd8,1'b1,1'b0,2'd2,1'b1,1'b0,2'd1,KA,  1'b0,5'd0},  // R3 stage two
        '{2'd0,1'b0,1'b0,2'd0,1'b0,1'b0,1'b0,4'd8,1'b0,1'b1,2'd2,1'b1,1'b1,2'd1,KA,  1'b0,5'd0},  // R6 enable clear
        '{2'd1,1'b0,1'b0,2'd0,1'b0,1'b0,1'b0,4'd8,1'b1,1'b1,2'd2,1'b1,1'b1,2'd1,KA,  1'b0,5'd0},  // R4 S passes
        '{2'd3,1'b0,1'b1,2'd0,1'b0,1'b0,1'b0,4'd8,1'b1,1'b0,2'd2,1'b1,1'b1,2'd1,KA,  1'b1,5'd13}, // R4 mprv to U
        '{2'd3,1'b0,1'b1,2'd1,1'b0,1'b0,1'b0,4'd8,1'b1,1'b0,2'd2,1'b1,1'b1,2'd1,KA,  1'b0,5'd0},  // R4 mprv to S
        '{2'd3,1'b0,1'b0,2'd0,1'b0,1'b0,1'b0,4'd8,1'b1,1'b1,2'd2,1'b1,1'b1,2'd1,KA,  1'b0,5'd0},  // R4 plain M
        '{2'd1,1'b0,1'b0,2'd0,1'b1,1'b0,1'b0,4'd8,1'b1,1'b0,2'd2,1'b1,1'b1,2'd1,KA,  1'b1,5'd13}, // R4 R5 hyp from S
        '{2'd1,1'b0,1'b0,2'd0,1'b1,1'b1,1'b0,4'd8,1'b1,1'b1,2'd2,1'b1,1'b1,2'd1,KA,  1'b0,5'd0},  // R4 spvp set
        '{2'd0,1'b0,1'b0,2'd0,1'b1,1'b0,1'b1,4'd8,1'b0,1'b1,2'd2,1'b1,1'b1,2'd2,KA,  1'b1,5'd15}, // R5 hyp enable
        '{2'd0,1'b0,1'b0,2'd0,1'b1,1'b0,1'b1,4'd8,1'b1,1'b0,2'd2,1'b1,1'b1,2'd2,KA,  1'b0,5'd0},  // R5 usr ignored
        '{2'd0,1'b1,1'b0,2'd0,1'b0,1'b0,1'b0,4'd8,1'b1,1'b0,2'd2,1'b1,1'b1,2'd1,KA,  1'b1,5'd13}, // R4 R5 guest user
        '{2'd0,1'b0,1'b0,2'd0,1'b0,1'b0,1'b0,4'd8,1'b1,1'b0,2'd1,1'b1,1'b1,2'd1,LA32,1'b1,5'd13}, // R7 sxl 1
        '{2'd0,1'b0,1'b0,2'd0,1'b0,1'b0,1'b0,4'd8,1'b1,1'b0,2'd0,1'b1,1'b1,2'd1,LA32,1'b1,5'd13}, // R7 sxl 0
        '{2'd0,1'b0,1'b0,2'd0,1'b0,1'b0,1'b0,4'd8,1'b1,1'b0,2'd2,1'b1,1'b1,2'd1,LA32,1'b0,5'd0},  // R7 wide low
        '{2'd0,1'b0,1'b0,2'd0,1'b0,1'b0,1'b0,4'd8,1'b1,1'b0,2'd1,1'b1,1'b1,2'd1,KA,  1'b0,5'd0},  // R7 narrow clear
        '{2'd0,1'b0,1'b0,2'd0,1'b0,1'b0,1'b0,4'd8,1'b1,1'b0,2'd3,1'b1,1'b1,2'd1,KA,  1'b1,5'd13}, // R7 sxl 3
        '{2'd0,1'b0,1'b0,2'd0,1'b1,1'b0,1'b0,4'd8,1'b1,1'b1,2'd2,1'b1,1'b1,2'd1,KA,  1'b0,5'd0}   // R4 hu clear
    };

    logic            clk;
    logic            rst;
    logic            req_valid;
    logic [1:0]      cur_priv;
    logic            cur_virt;
    logic            mprv;
    logic [1:0]      mpp;
    logic            hyp_access;
    logic            spvp;
    logic            hu;
    logic [3:0]      atp_mode;
    logic            usr_guard_en;
    logic            hyp_guard_en;
    logic [1:0]      sxl;
    logic            ext_en;
    logic            stage_one;
    logic [1:0]      acc_kind;
    logic [VA_W-1:0] vaddr;
    logic            rsp_valid;
    logic            rsp_fault;
    logic [4:0]      rsp_cause;

    int n_checks;
    int n_errors;
    bit finished;

    ukaddr_guard #(.VA_W(VA_W)) dut (
        .clk          (clk),
        .rst          (rst),
        .req_valid    (req_valid),
        .cur_priv     (cur_priv),
        .cur_virt     (cur_virt),
        .mprv         (mprv),
        .mpp          (mpp),
        .hyp_access   (hyp_access),
        .spvp         (spvp),
        .hu           (hu),
        .atp_mode     (atp_mode),
        .usr_guard_en (usr_guard_en),
        .hyp_guard_en (hyp_guard_en),
        .sxl          (sxl),
        .ext_en       (ext_en),
        .stage_one    (stage_one),
        .acc_kind     (acc_kind),
        .vaddr        (vaddr),
        .rsp_valid    (rsp_valid),
        .rsp_fault    (rsp_fault),
        .rsp_cause    (rsp_cause)
    );

    initial clk = 1'b0;
    always #(CLK_PERIOD/2) clk = ~clk;

    // Reference written from the requirements.
    function automatic logic [5:0] expect_of(input vec_t v);
        logic user;
        logic en;
        logic bitv;
        logic [4:0] c;
        user = 1'b0;
        if (v.hyp) begin
            if (!v.virt) begin
                if (v.priv == 2'd0)      user = v.hu;
                else if (v.priv != 2'd2) user = !v.spvp;
            end
        end else if (v.priv == 2'd3 && v.mprv) begin
            user = (v.mpp == 2'd0);
        end else begin
            user = (v.priv == 2'd0);
        end
        en   = (v.priv == 2'd0 && !v.virt && v.hyp) ? v.hen : v.sen;
        bitv = (v.sxl >= 2'd2) ? v.addr[63] : v.addr[31];
        case (v.kind)
            2'd0:    c = 5'd12;
            2'd1:    c = 5'd13;
            2'd2:    c = 5'd15;
            default: c = 5'd0;
        endcase
        if (v.ext && v.stg && v.mode == 4'd8 && v.kind != 2'd3 && user && en && bitv)
            return {1'b1, c};
        return 6'd0;
    endfunction

    task automatic drive(input vec_t v);
        cur_priv     = v.priv;
        cur_virt     = v.virt;
        mprv         = v.mprv;
        mpp          = v.mpp;
        hyp_access   = v.hyp;
        spvp         = v.spvp;
        hu           = v.hu;
        atp_mode     = v.mode;
        usr_guard_en = v.sen;
        hyp_guard_en = v.hen;
        sxl          = v.sxl;
        ext_en       = v.ext;
        stage_one    = v.stg;
        acc_kind     = v.kind;
        vaddr        = v.addr;
        req_valid    = 1'b1;
    endtask

    task automatic check_out(input string tag, input logic ev, input logic ef, input logic [4:0] ec);
        n_checks++;
        if (rsp_valid !== ev || rsp_fault !== ef || rsp_cause !== ec) begin
            n_errors++;
            $display("FAIL %s: got valid=%0b fault=%0b cause=%0d, expected valid=%0b fault=%0b cause=%0d",
                     tag, rsp_valid, rsp_fault, rsp_cause, ev, ef, ec);
        end
    endtask

    initial begin
        #(CLK_PERIOD * 20000);
        if (!finished) begin
            n_checks++;
            n_errors++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

    initial begin
        vec_t rv;
        logic [5:0] ex;
        n_checks = 0;
        n_errors = 0;
        finished = 0;
        rst = 1'b1;
        req_valid = 1'b0;
        drive(VT[0]);
        req_valid = 1'b0;
        repeat (3) @(negedge clk);
        check_out("R1 reset idle", 1'b0, 1'b0, 5'd0);
        rst = 1'b0;
        @(negedge clk);
        check_out("R9 idle after reset", 1'b0, 1'b0, 5'd0);

        // Table walk, back-to-back requests (CHAIN).
        for (int i = 0; i < N_VEC; i++) begin
            drive(VT[i]);
            @(negedge clk);
            check_out($sformatf("R1-path vector %0d", i), 1'b1, VT[i].flt, VT[i].cause);
        end

        // DRAIN after a faulting request: R9.
        drive(VT[0]);
        @(negedge clk);
        check_out("R8 fault before drain", 1'b1, 1'b1, 5'd13);
        req_valid = 1'b0;
        @(negedge clk);
        check_out("R9 drained", 1'b0, 1'b0, 5'd0);

        // Randomized sweep against reference.
        for (int k = 0; k < N_RAND; k++) begin
            rv.priv = 2'($urandom_range(0, 3));
            rv.virt = 1'($urandom_range(0, 1));
            rv.mprv = 1'($urandom_range(0, 1));
            rv.mpp  = 2'($urandom_range(0, 3));
            rv.hyp  = 1'($urandom_range(0, 1));
            rv.spvp = 1'($urandom_range(0, 1));
            rv.hu   = 1'($urandom_range(0, 1));
            rv.mode = ($urandom_range(0, 3) != 0) ? 4'd8 : 4'($urandom_range(0, 15));
            rv.sen  = 1'($urandom_range(0, 1));
            rv.hen  = 1'($urandom_range(0, 1));
            rv.sxl  = 2'($urandom_range(0, 3));
            rv.ext  = ($urandom_range(0, 7) != 0);
            rv.stg  = ($urandom_range(0, 7) != 0);
            rv.kind = 2'($urandom_range(0, 3));
            rv.addr = {32'($urandom), 32'($urandom)};
            ex = expect_of(rv);
            rv.flt = ex[5];
            rv.cause = ex[4:0];
            drive(rv);
            @(negedge clk);
            check_out($sformatf("R4 R5 R7 random %0d", k), 1'b1, rv.flt, rv.cause);
        end

        // Reset during a request clears the response slot: R1.
        drive(VT[1]);
        @(negedge clk);
        check_out("R8 store before reset", 1'b1, 1'b1, 5'd15);
        rst = 1'b1;
        @(negedge clk);
        check_out("R1 reset mid-request", 1'b0, 1'b0, 5'd0);
        rst = 1'b0;
        req_valid = 1'b0;
        @(negedge clk);
        check_out("R9 quiet after reset", 1'b0, 1'b0, 5'd0);

        finished = 1;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

endmodule